// File: doc/BRIEF.md
# Binary / Packed-BCD Add-Subtract Unit

This unit adds or subtracts two operands with carry, in either plain binary or packed BCD. A decimal select chooses the arithmetic. A byte select chooses the active width: 8 bits (two BCD digits) or 16 bits (four BCD digits). On subtract, carry-in means "no borrow pending" and carry-out means "no borrow produced". With that convention, multi-word arithmetic chains the carry flag straight from one operation into the next.

The datapath is a chain of 4-bit digit cells. Each cell applies its own decimal correction, so a digit that overflows or borrows is fixed locally and passes its carry onward. Byte mode reads the carry from the second digit and passes the upper byte of operand A through unchanged. Zero, negative and overflow flags are formed at the active width. Results and flags sit in one output register with an active-low asynchronous reset. The register keeps the arithmetic off the consumer's timing path.

Top module: `bcd_addsub`

## Requirements
- R1: Binary add (dec_i=0, sub_i=0, byte_i=0): {carry_o, result_o} = a_i + b_i + carry_i as a 17-bit unsigned sum.
- R2: Binary subtract (dec_i=0, sub_i=1): result = A - B - (1 - carry_i) modulo 2^width. carry_o=1 exactly when the unsigned difference did not go below zero.
- R3: Decimal add (dec_i=1, sub_i=0): when both operands hold valid BCD digits (each nibble 0..9), the result is the BCD encoding of (A + B + carry_i) mod 10^digits. carry_o=1 when that sum reaches 10^digits.
- R4: Decimal subtract (dec_i=1, sub_i=1): when both operands are valid BCD, the result is the BCD encoding of (A - B - (1 - carry_i)) mod 10^digits. carry_o=1 exactly when no borrow left the top digit.
- R5: Byte mode (byte_i=1): the operation uses bits 7:0 only, which is two digits in decimal mode. carry_o comes from bit 7 or digit 1, and result_o[15:8] equals a_i[15:8].
- R6: zero_o=1 exactly when the active-width part of result_o is all zeros (bits 7:0 in byte mode, bits 15:0 otherwise).
- R7: neg_o equals the top bit of the active width of result_o (bit 7 in byte mode, bit 15 otherwise).
- R8: In binary mode, ovf_o is the two's-complement overflow at the active width. In decimal mode, ovf_o is 0.
- R9: All outputs are registered and show the result of the inputs sampled at the previous rising clock edge. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | Operand A (minuend on subtract) |
| b_i | input | 16 | Operand B (subtrahend on subtract) |
| carry_i | input | 1 | Carry in; on subtract 1 means no borrow |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| byte_i | input | 1 | 1 selects 8-bit width, 0 selects 16-bit |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry / not-borrow out |
| zero_o | output | 1 | Registered zero flag at the active width |
| neg_o | output | 1 | Registered sign bit of the active width |
| ovf_o | output | 1 | Registered signed overflow (binary mode only) |

## Verification
Every output is due exactly one rising edge after the inputs that produce it are applied. There is no other latency in the block. The driver applies one operation per cycle on the falling edge and queues its expected result at the same time. The monitor compares one queued item shortly after each rising edge, so each comparison sees the register that captured that item's inputs. The reset state is checked while reset is held, before any operation is queued.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
  localparam int unsigned DIGIT_W      = 4;
  localparam int unsigned NUM_DIGITS   = 4;
  localparam int unsigned NARROW_DIGITS = 2;
  localparam int unsigned RADIX        = 10;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned DW = DIGIT_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  input  logic          sub_i,
  input  logic          dec_i,
  output logic [DW-1:0] s_o,
  output logic          c_o
);
  localparam logic [DW:0] LIMIT = (DW+1)'(RADIX - 1);
  localparam logic [DW:0] ADJ   = (DW+1)'((1 << DW) - RADIX);

  logic [DW-1:0] b_eff;
  logic [DW:0]   raw;
  logic [DW:0]   fix;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    raw   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_i};
    fix   = '0;
    s_o   = raw[DW-1:0];
    c_o   = raw[DW];
    if (dec_i) begin
      if (!sub_i) begin
        // digit overflowed radix: skip unused codes, carry onward
        if (raw > LIMIT) begin
          fix = raw + ADJ;
          s_o = fix[DW-1:0];
          c_o = 1'b1;
        end
      end else if (!raw[DW]) begin
        // digit borrowed: remove unused codes
        fix = raw - ADJ;
        s_o = fix[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned DW = DIGIT_W,
  parameter int unsigned ND = NUM_DIGITS,
  localparam int unsigned W = DW * ND
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          c_i,
  input  logic          sub_i,
  input  logic          dec_i,
  output logic [W-1:0]  sum_o,
  output logic [ND-1:0] carry_o
);
  logic [ND:0] chain;
  assign chain[0] = c_i;

  for (genvar g = 0; g < ND; g++) begin : g_digit
    bcd_digit_cell #(.DW(DW)) u_cell (
      .a_i   (a_i[g*DW +: DW]),
      .b_i   (b_i[g*DW +: DW]),
      .c_i   (chain[g]),
      .sub_i (sub_i),
      .dec_i (dec_i),
      .s_o   (sum_o[g*DW +: DW]),
      .c_o   (chain[g+1])
    );
  end

  assign carry_o = chain[ND:1];
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit #(
  parameter int unsigned W  = 16,
  parameter int unsigned NW = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  input  logic         sub_i,
  input  logic         dec_i,
  input  logic         byte_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  logic a_top, b_top;

  always_comb begin
    if (byte_i) begin
      zero_o = (res_i[NW-1:0] == '0);
      neg_o  = res_i[NW-1];
      a_top  = a_i[NW-1];
      b_top  = b_i[NW-1] ^ sub_i;
    end else begin
      zero_o = (res_i == '0);
      neg_o  = res_i[W-1];
      a_top  = a_i[W-1];
      b_top  = b_i[W-1] ^ sub_i;
    end
    ovf_o = !dec_i && (a_top == b_top) && (neg_o != a_top);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned DW  = DIGIT_W,
  parameter int unsigned ND  = NUM_DIGITS,
  parameter int unsigned NND = NARROW_DIGITS,
  localparam int unsigned W  = DW * ND,
  localparam int unsigned NW = DW * NND
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         dec_i,
  input  logic         byte_i,
  input  logic         sub_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  logic [W-1:0]  sum;
  logic [ND-1:0] dig_carry;
  logic [W-1:0]  res_d;
  logic          carry_d, zero_d, neg_d, ovf_d;

  bcd_digit_chain #(.DW(DW), .ND(ND)) u_chain (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (carry_i),
    .sub_i   (sub_i),
    .dec_i   (dec_i),
    .sum_o   (sum),
    .carry_o (dig_carry)
  );

  always_comb begin
    if (byte_i) begin
      res_d   = {a_i[W-1:NW], sum[NW-1:0]};
      carry_d = dig_carry[NND-1];
    end else begin
      res_d   = sum;
      carry_d = dig_carry[ND-1];
    end
  end

  bcd_flag_unit #(.W(W), .NW(NW)) u_flags (
    .a_i    (a_i),
    .b_i    (b_i),
    .res_i  (res_d),
    .sub_i  (sub_i),
    .dec_i  (dec_i),
    .byte_i (byte_i),
    .zero_o (zero_d),
    .neg_o  (neg_d),
    .ovf_o  (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= carry_d;
      zero_o   <= zero_d;
      neg_o    <= neg_d;
      ovf_o    <= ovf_d;
    end
  end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned NW = 8,
  parameter int unsigned DW = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         carry_i,
  input logic         dec_i,
  input logic         byte_i,
  input logic         sub_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o
);
  function automatic logic all_digits_ok(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W / DW; i++) begin
      if (v[i*DW +: DW] > DW'(9)) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_BIN_ADD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !sub_i && !byte_i) |=>
      ({carry_o, result_o} == $past({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, carry_i}))); // R1

  AST_DEC_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !byte_i && all_digits_ok(a_i) && all_digits_ok(b_i)) |=>
      all_digits_ok(result_o)); // R3

  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> (result_o[W-1:NW] == $past(a_i[W-1:NW]))); // R5

  AST_ZERO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> (zero_o == (result_o[NW-1:0] == '0))); // R6

  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |=> (zero_o == (result_o == '0))); // R6

  AST_NEG_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> (neg_o == result_o[NW-1])); // R7

  AST_NEG_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |=> (neg_o == result_o[W-1])); // R7

  AST_NO_OVF_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> !ovf_o); // R8
endmodule

bind bcd_addsub bcd_addsub_chk #(.W(W), .NW(NW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .carry_i  (carry_i),
  .dec_i    (dec_i),
  .byte_i   (byte_i),
  .sub_i    (sub_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o),
  .ovf_o    (ovf_o)
);

// File: tb/bcd_addsub_tb.sv
module bcd_addsub_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        carry_i = 1'b0, dec_i = 1'b0, byte_i = 1'b0, sub_i = 1'b0;
  logic [15:0] result_o;
  logic        carry_o, zero_o, neg_o, ovf_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        c, z, n, v;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bcd_addsub u_dut (
    .clk_i, .rst_ni, .a_i, .b_i, .carry_i, .dec_i, .byte_i, .sub_i,
    .result_o, .carry_o, .zero_o, .neg_o, .ovf_o
  );

  function automatic int bcd_val(logic [15:0] v, int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] to_bcd(int v, int nd);
    logic [15:0] r = '0;
    for (int i = 0; i < nd; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic drive(logic [15:0] a, logic [15:0] b, logic c, logic dec,
                       logic byt, logic sub, string tag);
    exp_t e;
    int w, nd, lim, s;
    logic [15:0] mask, r, bb;
    w    = byt ? 8 : 16;
    nd   = byt ? 2 : 4;
    mask = byt ? 16'h00ff : 16'hffff;
    e.v  = 1'b0;
    if (!dec) begin
      bb = sub ? ~b : b;
      s  = int'(a & mask) + int'(bb & mask) + int'(c);
      e.c = s[w];
      r  = 16'(s) & mask;
      e.v = (a[w-1] == bb[w-1]) && (r[w-1] != a[w-1]);
    end else begin
      lim = byt ? 100 : 10000;
      if (!sub) begin
        s   = bcd_val(a, nd) + bcd_val(b, nd) + int'(c);
        e.c = (s >= lim);
        s   = s % lim;
      end else begin
        s   = bcd_val(a, nd) - bcd_val(b, nd) - (1 - int'(c));
        e.c = (s >= 0);
        if (s < 0) s += lim;
      end
      r = to_bcd(s, nd);
    end
    e.res = byt ? {a[15:8], r[7:0]} : r;
    e.z   = ((r & mask) == '0);
    e.n   = r[w-1];
    e.tag = tag;
    @(negedge clk_i);
    a_i = a; b_i = b; carry_i = c; dec_i = dec; byte_i = byt; sub_i = sub;
    sb_q.push_back(e);
  endtask

  // monitor: each item is due one rising edge after it was driven
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_checks++;
        if ({result_o, carry_o, zero_o, neg_o, ovf_o} != {e.res, e.c, e.z, e.n, e.v}) begin
          n_fails++;
          $display("FAIL %s: res=%h c=%b z=%b n=%b v=%b expected res=%h c=%b z=%b n=%b v=%b",
                   e.tag, result_o, carry_o, zero_o, neg_o, ovf_o,
                   e.res, e.c, e.z, e.n, e.v);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ace_b00c;
    a_i = 16'hffff; b_i = 16'hffff; carry_i = 1'b1;
    repeat (3) @(negedge clk_i);
    n_checks++;
    if ({result_o, carry_o, zero_o, neg_o, ovf_o} != '0) begin
      n_fails++;
      $display("FAIL R9 reset: got %h/%b%b%b%b expected 0000/0000",
               result_o, carry_o, zero_o, neg_o, ovf_o);
    end
    rst_ni = 1'b1;

    // R1 binary add
    drive(16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, "R1 add");
    drive(16'h1234, 16'h4321, 1'b1, 1'b0, 1'b0, 1'b0, "R1 add carry-in");
    drive(16'hffff, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R1 R6 wrap to zero");
    drive(16'h7fff, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R8 R7 signed overflow");
    // R2 binary subtract
    drive(16'h5000, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b1, "R2 sub no borrow");
    drive(16'h0000, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1, "R2 R7 sub borrow");
    drive(16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, "R2 borrow-in");
    drive(16'h8000, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1, "R8 sub overflow");
    // R3 decimal add
    drive(16'h0999, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, "R3 ripple adjust");
    drive(16'h9999, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, "R3 R6 decimal wrap");
    drive(16'h4567, 16'h5678, 1'b1, 1'b1, 1'b0, 1'b0, "R3 carry-in");
    drive(16'h0089, 16'h0089, 1'b0, 1'b1, 1'b0, 1'b0, "R3 nibble carry");
    // R4 decimal subtract
    drive(16'h1000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R4 ripple borrow");
    drive(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R4 decimal underflow");
    drive(16'h5000, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b1, "R4 borrow-in");
    // R5 byte mode
    drive(16'hab7f, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, "R5 R8 byte overflow");
    drive(16'h12ff, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, "R5 R6 byte carry");
    drive(16'h1299, 16'h5501, 1'b0, 1'b1, 1'b1, 1'b0, "R5 byte decimal add");
    drive(16'h3400, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, "R5 byte decimal sub");
    drive(16'h0000, 16'hff00, 1'b0, 1'b0, 1'b1, 1'b0, "R5 R6 upper ignored");

    for (int i = 0; i < 200; i++) begin
      logic [15:0] ra, rb;
      logic [5:0]  ctl;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra   = lfsr[15:0];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb   = lfsr[15:0];
      ctl  = lfsr[21:16];
      if (ctl[1]) begin
        ra = to_bcd(int'(ra) % 10000, 4);
        rb = to_bcd(int'(rb) % 10000, 4);
      end
      drive(ra, rb, ctl[0], ctl[1], ctl[2], ctl[3],
            ctl[1] ? "R3 R4 random decimal" : "R1 R2 random binary");
    end

    @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule